// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment base and a 16-bit offset into a 20-bit physical memory address. It sits between an operand decoder and the memory interface. The decoder presents an access kind and the current register values. The block forms the offset for that kind of access and picks the segment register that goes with it. If an override is present and the access kind permits one, the override segment is used in place of the default. The segment value, with four zero bits appended below it, is then added to the offset.

Data accesses have five kinds: a bare displacement, a lone pointer register, a displacement plus a base register, a displacement plus an index register, and a displacement plus both a base and an index register. Instruction fetch, stack access and string-destination access have fixed segment and offset pairings that no override can change. The result is registered. It appears one clock after the request strobe, together with a one-cycle valid pulse and the code of the segment that was used.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `addr_valid`=0, `phys_addr`=0 and `seg_used`=0.
- R2: The physical address is (segment value × 16 + offset) modulo 2^20. For example, segment 348AH with offset 4214H gives 38AB4H, and segment FFFFH with offset 0020H wraps to 00010H.
- R3: Offset sums are taken modulo 2^16 before the segment base is added. For example, displacement FFFFH plus base register 0002H gives offset 0001H.
- R4: Mode code 0 (direct) uses `disp` as the offset and, without an override, data segment DS (`seg_used`=1).
- R5: Mode code 1 (pointer register) uses the register chosen by `ind_sel` as the offset (0=BX, 1=SI, 2=DI, 3=BP) and ignores `disp`. The default segment is SS (code 2) for BP and DS (code 1) otherwise. For example, DS=5004H with DI=0020H gives 50060H.
- R6: Mode code 2 (based) gives disp+base, mode code 3 (indexed) gives disp+index, and mode code 4 (based-indexed) gives disp+base+index. `base_sel` picks the base register (0=BX, 1=BP) and `idx_sel` picks the index register (0=SI, 1=DI). The default segment is SS when BP is the base and DS otherwise.
- R7: In mode codes 0 to 4, `ovr_en`=1 replaces the default segment with `ovr_seg`, encoded 0=CS, 1=DS, 2=SS, 3=ES. `seg_used` uses the same encoding.
- R8: Mode code 5 forms CS:IP, mode code 6 forms SS:SP, and mode code 7 forms ES:DI. In these modes `ovr_en` and `ovr_seg` have no effect.
- R9: `addr_valid` is high for exactly the one cycle after each cycle in which `req` is high. `phys_addr` and `seg_used` change only one clock after a request and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe, one address per high cycle |
| mode | input | 3 | Access kind, codes 0 to 7 as in R4 to R8 |
| ind_sel | input | 2 | Pointer register for mode 1 |
| base_sel | input | 1 | Base register: 0=BX, 1=BP |
| idx_sel | input | 1 | Index register: 0=SI, 1=DI |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| disp | input | 16 | Displacement |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| reg_sp | input | 16 | SP value |
| reg_ip | input | 16 | IP value |
| seg_cs | input | 16 | CS value |
| seg_ds | input | 16 | DS value |
| seg_ss | input | 16 | SS value |
| seg_es | input | 16 | ES value |
| phys_addr | output | 20 | Registered physical address |
| addr_valid | output | 1 | One-cycle strobe marking a new address |
| seg_used | output | 2 | Code of the segment applied |

## Verification
The directed cases come first: the worked addresses, an offset sum that passes FFFFH, and a segment near the top that carries past bit 19. These separate a correct modulo-2^16 offset from one that is widened too early, and a correct 20-bit truncation from an extra carry bit. Each data mode is then tried with BX and then BP as the base, so that a wrong default segment shows up. The same operands are tried with every override code, and again in the fixed modes where the override must be ignored. A long random run with gaps between requests then checks that the strobe and the held values behave correctly with idle cycles, back-to-back requests and every register choice.

// File: rtl/seg_addr_pkg.sv
// Shared encodings for the segmented address generator.
// Assumes: mode and segment codes are fixed by the block's requirements.
package seg_addr_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_REGIND   = 3'd1,
        AM_BASED    = 3'd2,
        AM_INDEXED  = 3'd3,
        AM_BASEIDX  = 3'd4,
        AM_FETCH    = 3'd5,
        AM_STACK    = 3'd6,
        AM_STRDST   = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SG_CS = 2'd0,
        SG_DS = 2'd1,
        SG_SS = 2'd2,
        SG_ES = 2'd3
    } seg_e;

    localparam logic [1:0] PTR_BX = 2'd0;
    localparam logic [1:0] PTR_SI = 2'd1;
    localparam logic [1:0] PTR_DI = 2'd2;
    localparam logic [1:0] PTR_BP = 2'd3;

endpackage

// File: rtl/seg_offset_calc.sv
// Offset former: picks the operands for the access kind and sums them
// modulo 2^OFF_W. It also reports whether BP is the base register.
// Assumes: all register operands are OFF_W bits wide; purely combinational.
module seg_offset_calc
    import seg_addr_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  amode_e             mode,
    input  logic [1:0]         ind_sel,
    input  logic               base_sel,
    input  logic               idx_sel,
    input  logic [OFF_W-1:0]   disp,
    input  logic [OFF_W-1:0]   reg_bx,
    input  logic [OFF_W-1:0]   reg_bp,
    input  logic [OFF_W-1:0]   reg_si,
    input  logic [OFF_W-1:0]   reg_di,
    input  logic [OFF_W-1:0]   reg_sp,
    input  logic [OFF_W-1:0]   reg_ip,
    output logic [OFF_W-1:0]   offset,
    output logic               uses_bp
);

    logic [OFF_W-1:0] base_val;
    logic [OFF_W-1:0] idx_val;
    logic [OFF_W-1:0] ptr_val;

    // Operand muxes for base, index and lone pointer register
    always_comb begin
        base_val = base_sel ? reg_bp : reg_bx;
        idx_val  = idx_sel  ? reg_di : reg_si;
        unique case (ind_sel)
            PTR_BX:  ptr_val = reg_bx;
            PTR_SI:  ptr_val = reg_si;
            PTR_DI:  ptr_val = reg_di;
            default: ptr_val = reg_bp;
        endcase
    end

    // Offset sum per access kind, wrapping at OFF_W bits
    always_comb begin
        unique case (mode)
            AM_DIRECT:  offset = disp;
            AM_REGIND:  offset = ptr_val;
            AM_BASED:   offset = disp + base_val;
            AM_INDEXED: offset = disp + idx_val;
            AM_BASEIDX: offset = disp + base_val + idx_val;
            AM_FETCH:   offset = reg_ip;
            AM_STACK:   offset = reg_sp;
            default:    offset = reg_di;
        endcase
    end

    // Flag BP use so the default segment can switch to the stack segment
    always_comb begin
        unique case (mode)
            AM_REGIND:             uses_bp = (ind_sel == PTR_BP);
            AM_BASED, AM_BASEIDX:  uses_bp = base_sel;
            default:               uses_bp = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_select.sv
// Segment chooser: default segment per access kind, override for data
// kinds only, then a mux that picks that segment register's value.
// Assumes: the override code uses the seg_e encoding; purely combinational.
module seg_select
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  amode_e             mode,
    input  logic               uses_bp,
    input  logic               ovr_en,
    input  seg_e               ovr_seg,
    input  logic [SEG_W-1:0]   seg_cs,
    input  logic [SEG_W-1:0]   seg_ds,
    input  logic [SEG_W-1:0]   seg_ss,
    input  logic [SEG_W-1:0]   seg_es,
    output seg_e               seg_code,
    output logic [SEG_W-1:0]   seg_val
);

    seg_e dflt;
    logic fixed_kind;

    // Default segment and whether the kind refuses an override
    always_comb begin
        fixed_kind = 1'b0;
        unique case (mode)
            AM_FETCH:  begin dflt = SG_CS; fixed_kind = 1'b1; end
            AM_STACK:  begin dflt = SG_SS; fixed_kind = 1'b1; end
            AM_STRDST: begin dflt = SG_ES; fixed_kind = 1'b1; end
            default:   dflt = uses_bp ? SG_SS : SG_DS;
        endcase
    end

    // Apply the override where the kind allows it
    always_comb begin
        seg_code = (ovr_en && !fixed_kind) ? ovr_seg : dflt;
    end

    // Select the segment register value
    always_comb begin
        unique case (seg_code)
            SG_CS:   seg_val = seg_cs;
            SG_DS:   seg_val = seg_ds;
            SG_SS:   seg_val = seg_ss;
            default: seg_val = seg_es;
        endcase
    end

endmodule

// File: rtl/seg_addr_reg.sv
// Output stage: shifts the segment up by SHIFT bits, adds the offset
// modulo 2^PA_W and registers the address, the segment code and a strobe.
// Assumes: OFF_W <= PA_W and SEG_W + SHIFT >= PA_W; synchronous active-low reset.
module seg_addr_reg
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [SEG_W-1:0]   seg_val,
    input  seg_e               seg_code,
    input  logic [OFF_W-1:0]   offset,
    output logic [PA_W-1:0]    phys_addr,
    output logic               addr_valid,
    output seg_e               seg_used
);

    localparam int BASE_W = SEG_W + SHIFT;

    logic [BASE_W-1:0] base_full;
    logic [PA_W-1:0]   sum;

    // Segment base with zero low bits, plus offset, truncated to PA_W
    always_comb begin
        base_full = {seg_val, {SHIFT{1'b0}}};
        sum       = PA_W'(base_full) + PA_W'(offset);
    end

    // Capture on request, hold otherwise; strobe follows the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr  <= '0;
            addr_valid <= 1'b0;
            seg_used   <= SG_CS;
        end else begin
            addr_valid <= req;
            if (req) begin
                phys_addr <= sum;
                seg_used  <= seg_code;
            end
        end
    end

    // R9: a request yields a strobe on the next cycle
    assert_valid_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> addr_valid);

    // R9: no request, no strobe
    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !addr_valid);

    // R9: the address and segment hold across idle cycles
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(phys_addr) && $stable(seg_used)));

endmodule

// File: rtl/seg_addr_gen.sv
// Segmented physical address generator top: forms the offset, picks the
// segment (default or override) and registers the physical address.
// Assumes: request inputs are stable around the rising edge; output is
// valid for one cycle, one clock after each request.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [2:0]         mode,
    input  logic [1:0]         ind_sel,
    input  logic               base_sel,
    input  logic               idx_sel,
    input  logic               ovr_en,
    input  logic [1:0]         ovr_seg,
    input  logic [OFF_W-1:0]   disp,
    input  logic [OFF_W-1:0]   reg_bx,
    input  logic [OFF_W-1:0]   reg_bp,
    input  logic [OFF_W-1:0]   reg_si,
    input  logic [OFF_W-1:0]   reg_di,
    input  logic [OFF_W-1:0]   reg_sp,
    input  logic [OFF_W-1:0]   reg_ip,
    input  logic [SEG_W-1:0]   seg_cs,
    input  logic [SEG_W-1:0]   seg_ds,
    input  logic [SEG_W-1:0]   seg_ss,
    input  logic [SEG_W-1:0]   seg_es,
    output logic [PA_W-1:0]    phys_addr,
    output logic               addr_valid,
    output logic [1:0]         seg_used
);

    amode_e           mode_e;
    seg_e             ovr_e;
    seg_e             seg_code;
    seg_e             seg_used_e;
    logic [OFF_W-1:0] offset;
    logic [SEG_W-1:0] seg_val;
    logic             uses_bp;

    // Cast plain port codes to the shared types
    always_comb begin
        mode_e   = amode_e'(mode);
        ovr_e    = seg_e'(ovr_seg);
        seg_used = seg_used_e;
    end

    seg_offset_calc #(.OFF_W(OFF_W)) i_off (
        .mode     (mode_e),
        .ind_sel  (ind_sel),
        .base_sel (base_sel),
        .idx_sel  (idx_sel),
        .disp     (disp),
        .reg_bx   (reg_bx),
        .reg_bp   (reg_bp),
        .reg_si   (reg_si),
        .reg_di   (reg_di),
        .reg_sp   (reg_sp),
        .reg_ip   (reg_ip),
        .offset   (offset),
        .uses_bp  (uses_bp)
    );

    seg_select #(.SEG_W(SEG_W)) i_sel (
        .mode     (mode_e),
        .uses_bp  (uses_bp),
        .ovr_en   (ovr_en),
        .ovr_seg  (ovr_e),
        .seg_cs   (seg_cs),
        .seg_ds   (seg_ds),
        .seg_ss   (seg_ss),
        .seg_es   (seg_es),
        .seg_code (seg_code),
        .seg_val  (seg_val)
    );

    seg_addr_reg #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) i_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .seg_val    (seg_val),
        .seg_code   (seg_code),
        .offset     (offset),
        .phys_addr  (phys_addr),
        .addr_valid (addr_valid),
        .seg_used   (seg_used_e)
    );

    // R8: instruction fetch always lands in the code segment
    assert_fetch_uses_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd5) |=> (seg_used == 2'd0));

    // R8: stack access always lands in the stack segment
    assert_stack_uses_ss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd6) |=> (seg_used == 2'd2));

    // R8: string destination always lands in the extra segment
    assert_strdst_uses_es_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd7) |=> (seg_used == 2'd3));

    // R7: an override on a data access is the segment reported next cycle
    assert_override_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ovr_en && mode <= 3'd4) |=> (seg_used == $past(ovr_seg)));

    // R4: a direct access with no override uses the data segment
    assert_direct_default_ds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ovr_en && mode == 3'd0) |=> (seg_used == 2'd1));

endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ind_sel = '0;
    logic        base_sel = 1'b0;
    logic        idx_sel = 1'b0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [15:0] disp = '0, reg_bx = '0, reg_bp = '0, reg_si = '0;
    logic [15:0] reg_di = '0, reg_sp = '0, reg_ip = '0;
    logic [15:0] seg_cs = '0, seg_ds = '0, seg_ss = '0, seg_es = '0;
    logic [19:0] phys_addr;
    logic        addr_valid;
    logic [1:0]  seg_used;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R2";

    // model state
    int    e_addr = 0;
    int    e_seg = 0;
    bit    e_valid = 0;
    string e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_gen i_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ind_sel(ind_sel),
        .base_sel(base_sel), .idx_sel(idx_sel), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
        .reg_di(reg_di), .reg_sp(reg_sp), .reg_ip(reg_ip), .seg_cs(seg_cs),
        .seg_ds(seg_ds), .seg_ss(seg_ss), .seg_es(seg_es),
        .phys_addr(phys_addr), .addr_valid(addr_valid), .seg_used(seg_used)
    );

    function automatic int seg_value(int code);
        case (code)
            0: return int'(seg_cs);
            1: return int'(seg_ds);
            2: return int'(seg_ss);
            default: return int'(seg_es);
        endcase
    endfunction

    // Behavioural model of one request, from the requirements
    always @(posedge clk) begin
        int off, sg, b, x, p;
        bit bp_used, fixed;
        if (!rst_n) begin
            e_valid <= 0; e_addr <= 0; e_seg <= 0; e_tag <= "R1";
        end else begin
            e_valid <= req;
            if (req) begin
                b = base_sel ? int'(reg_bp) : int'(reg_bx);
                x = idx_sel ? int'(reg_di) : int'(reg_si);
                p = (ind_sel == 0) ? int'(reg_bx) : (ind_sel == 1) ? int'(reg_si) :
                    (ind_sel == 2) ? int'(reg_di) : int'(reg_bp);
                bp_used = 0; fixed = 0; off = 0; sg = 1;
                case (mode)
                    0: off = int'(disp);
                    1: begin off = p; bp_used = (ind_sel == 3); end
                    2: begin off = int'(disp) + b; bp_used = base_sel; end
                    3: off = int'(disp) + x;
                    4: begin off = int'(disp) + b + x; bp_used = base_sel; end
                    5: begin off = int'(reg_ip); sg = 0; fixed = 1; end
                    6: begin off = int'(reg_sp); sg = 2; fixed = 1; end
                    default: begin off = int'(reg_di); sg = 3; fixed = 1; end
                endcase
                off = off % 65536;
                if (!fixed) sg = bp_used ? 2 : 1;
                if (!fixed && ovr_en) sg = int'(ovr_seg);
                e_seg  <= sg;
                e_addr <= (seg_value(sg) * 16 + off) % 1048576;
                e_tag  <= cur_tag;
            end
        end
    end

    // Compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (addr_valid !== e_valid) begin
                n_bad++;
                $display("FAIL R9 addr_valid actual=%0b expected=%0b", addr_valid, e_valid);
            end
            n_cmp++;
            if (int'(phys_addr) != e_addr) begin
                n_bad++;
                $display("FAIL %s phys_addr actual=%05h expected=%05h", e_tag, phys_addr, e_addr);
            end
            n_cmp++;
            if (int'(seg_used) != e_seg) begin
                n_bad++;
                $display("FAIL %s seg_used actual=%0d expected=%0d", e_tag, seg_used, e_seg);
            end
        end
    end

    task automatic cyc(input logic r, input string t);
        @(negedge clk);
        req = r;
        cur_tag = t;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state checked explicitly
        n_cmp++;
        if (addr_valid !== 1'b0 || phys_addr !== 20'h0 || seg_used !== 2'd0) begin
            n_bad++;
            $display("FAIL R1 reset actual=%0b/%05h/%0d expected=0/00000/0",
                     addr_valid, phys_addr, seg_used);
        end
        rst_n = 1'b1;
        cyc(1'b0, "R9");

        // R5: worked pointer example, DS=5004 DI=0020
        seg_ds = 16'h5004; reg_di = 16'h0020; mode = 3'd1; ind_sel = 2'd2;
        disp = 16'h1111;
        cyc(1'b1, "R5");
        cyc(1'b0, "R9");
        // R8 and R2: fetch from 348A:4214, override ignored
        seg_cs = 16'h348A; reg_ip = 16'h4214; mode = 3'd5; ovr_en = 1'b1; ovr_seg = 2'd3;
        cyc(1'b1, "R8");
        ovr_en = 1'b0;
        // R3: offset wraps at 16 bits
        mode = 3'd2; base_sel = 1'b0; disp = 16'hFFFF; reg_bx = 16'h0002; seg_ds = 16'h1000;
        cyc(1'b1, "R3");
        // R2: 20-bit wrap of the final sum
        mode = 3'd0; disp = 16'h0020; ovr_en = 1'b1; ovr_seg = 2'd3; seg_es = 16'hFFFF;
        cyc(1'b1, "R2");
        // R4: direct, default DS
        ovr_en = 1'b0; seg_ds = 16'h2000; disp = 16'h0123;
        cyc(1'b1, "R4");
        // R6: BP-based defaults to SS, based-indexed sum
        seg_ss = 16'h3000; reg_bp = 16'h0100; reg_si = 16'h0010; mode = 3'd4; base_sel = 1'b1;
        idx_sel = 1'b0; disp = 16'h0004;
        cyc(1'b1, "R6");
        // R5: BP pointer defaults to SS
        mode = 3'd1; ind_sel = 2'd3;
        cyc(1'b1, "R5");
        // R7: each override code on a data access
        for (int k = 0; k < 4; k++) begin
            mode = 3'd3; idx_sel = 1'b1; ovr_en = 1'b1; ovr_seg = 2'(k);
            cyc(1'b1, "R7");
        end
        // R8: stack and string destination ignore override
        mode = 3'd6; reg_sp = 16'hFFE0; seg_ss = 16'h5000;
        cyc(1'b1, "R8");
        mode = 3'd7;
        cyc(1'b1, "R8");
        ovr_en = 1'b0;
        // R9: idle inputs changing must not move outputs
        mode = 3'd0; disp = 16'hBEEF;
        cyc(1'b0, "R9");
        cyc(1'b0, "R9");

        // Random traffic covering all modes, selects and overrides
        for (int i = 0; i < 3000; i++) begin
            mode = 3'($urandom_range(0, 7)); ind_sel = 2'($urandom);
            base_sel = 1'($urandom); idx_sel = 1'($urandom);
            ovr_en = 1'($urandom); ovr_seg = 2'($urandom);
            disp = 16'($urandom); reg_bx = 16'($urandom); reg_bp = 16'($urandom);
            reg_si = 16'($urandom); reg_di = 16'($urandom); reg_sp = 16'($urandom);
            reg_ip = 16'($urandom); seg_cs = 16'($urandom); seg_ds = 16'($urandom);
            seg_ss = 16'($urandom); seg_es = 16'($urandom);
            cyc(1'($urandom_range(0, 9) < 7), (mode <= 3'd4 && ovr_en) ? "R7" :
                (mode == 3'd0) ? "R4" : (mode == 3'd1) ? "R5" :
                (mode <= 3'd4) ? "R6" : "R8");
        end
        cyc(1'b0, "R9");
        cyc(1'b0, "R9");
        finish_run();
    end

endmodule